// File: doc/BRIEF.md
# Hardware Breakpoint Match Unit

This block watches the accesses a core makes and compares each one against four programmable breakpoints. Each breakpoint has an address register plus a condition code and a length code held in a shared control register. When an access falls inside a breakpoint's window and is of the kind that breakpoint watches, the breakpoint's status flag is raised. A one-cycle debug-trap pulse is raised only if that breakpoint is enabled, either locally or globally. Local enables are dropped when the core switches tasks, while global enables survive the switch.

Software reaches the registers through a small indexed port: indices 0 to 3 are the breakpoint addresses, 6 is status and 7 is control. A protection mode guards that port. While it is on, any read or write attempt is suppressed and raises a trap instead, so a debugger can catch code that tampers with the breakpoint registers. The access monitor is a passive tap: it carries a valid strobe but no ready, because the block never back-pressures the core. An access is consumed in the cycle its valid is high.

Top module: `bkpt_match_unit`

## Requirements
- R1: After reset, control (index 7) reads 0x00000400, status (index 6) reads 0, address registers (indices 0 to 3) read 0 and `trap` is low.
- R2: Address registers are read/write. Status keeps bits 3:0 and 13, and its other bits read 0. Control keeps bits 7:0, 13 and 31:16. Control bit 10 always reads 1 and its other bits read 0. Indices 4 and 5 read 0 and ignore writes.
- R3: Breakpoint n is enabled by control bit 2n (local) or bit 2n+1 (global), and either one alone is enough to make its match trap.
- R4: Breakpoint n's condition sits in control bits 17+4n:16+4n, and its length code sits in bits 19+4n:18+4n. Length codes are 00=1 byte, 01=2, 11=4 and 10=8. An access of `acc_size` s covers 2^s bytes starting at `acc_addr`.
- R5: A data or I/O breakpoint matches when the accessed bytes overlap the window [A & ~(L-1), (A & ~(L-1)) + L-1], where A is the address register and L is the decoded length.
- R6: Access kinds are 0=fetch, 1=data read, 2=data write, 3=I/O read and 4=I/O write. Condition 01 matches data writes only. Condition 11 matches data reads and writes. Neither of them matches fetches or I/O.
- R7: Condition 10 matches I/O reads and writes only while `dbg_ext_en` is high. Otherwise it never matches.
- R8: Condition 00 matches only a fetch whose address equals the address register exactly, and its length field is ignored.
- R9: A valid access that matches sets status bit n whatever the enables are. `trap` is a one-cycle pulse in the cycle after a valid access that matches an enabled breakpoint.
- R10: When a valid access traps, status bits 3:0 are loaded with that access's full match vector. A valid access that does not trap ORs its matches into them.
- R11: `task_switch` clears all local enable bits and leaves global enables unchanged. It takes precedence over a control write in the same cycle.
- R12: While control bit 13 is set, any register read or write is suppressed: writes have no effect and read data is 0. The attempt sets status bit 13, pulses `trap` in the next cycle and clears control bit 13.
- R13: Status bit 13 is changed only by software writes to status and by R12. Data traps leave it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_idx | input | 3 | Register index (0-3 address, 6 status, 7 control) |
| reg_wdata | input | 32 | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (used for protection detection) |
| reg_rdata | output | 32 | Combinational read data for `reg_idx` |
| acc_valid | input | 1 | Monitored access is valid this cycle |
| acc_addr | input | 32 | Access start address |
| acc_kind | input | 3 | Access kind (see R6) |
| acc_size | input | 2 | Access size, 2^size bytes |
| dbg_ext_en | input | 1 | Allows I/O breakpoints to match |
| task_switch | input | 1 | Task-switch strobe, clears local enables |
| trap | output | 1 | Debug-trap pulse |
| status_o | output | 32 | Live status register |

## Verification
Each access and each register write is registered once. Its trap pulse, status bits and register contents are therefore due one cycle after the cycle in which the stimulus was presented. Read data is combinational and is due in the same cycle. The bench drives on the falling edge and samples at the next falling edge for registered results. For read data it samples shortly after setting the index. It also samples one more falling edge later to confirm that the trap has gone low again. A near-exhaustive sweep covers every length code, every access size and addresses on both sides of the window. It compares against an overlap computed in plain integer arithmetic.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  localparam int REG_W = 32;

  localparam logic [2:0] KIND_FETCH = 3'd0;
  localparam logic [2:0] KIND_DRD   = 3'd1;
  localparam logic [2:0] KIND_DWR   = 3'd2;
  localparam logic [2:0] KIND_IORD  = 3'd3;
  localparam logic [2:0] KIND_IOWR  = 3'd4;

  localparam logic [1:0] COND_EXEC = 2'b00;
  localparam logic [1:0] COND_WR   = 2'b01;
  localparam logic [1:0] COND_IO   = 2'b10;
  localparam logic [1:0] COND_RW   = 2'b11;

  localparam logic [2:0] IDX_STAT = 3'd6;
  localparam logic [2:0] IDX_CTRL = 3'd7;

  localparam int CTRL_PROT_BIT = 13;
  localparam int CTRL_FIELD_LO = 16;
  localparam int STAT_PROT_BIT = 13;
  localparam logic [REG_W-1:0] CTRL_KEEP = 32'hFFFF_20FF;
  localparam logic [REG_W-1:0] CTRL_ONES = 32'h0000_0400;

  typedef struct packed {
    logic [1:0] len;
    logic [1:0] cond;
  } bp_cfg_t;

  function automatic logic [3:0] len_bytes(input logic [1:0] code);
    case (code)
      2'b00:   len_bytes = 4'd1;
      2'b01:   len_bytes = 4'd2;
      2'b10:   len_bytes = 4'd8;
      default: len_bytes = 4'd4;
    endcase
  endfunction
endpackage

// File: rtl/bkpt_cmp.sv
module bkpt_cmp
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] bp_addr,
  input  bp_cfg_t           cfg,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [2:0]        acc_kind,
  input  logic [1:0]        acc_size,
  input  logic              io_ext_en,
  output logic              hit
);
  localparam int AW1 = ADDR_W + 1;

  logic [ADDR_W-1:0] len_m1;
  logic [ADDR_W-1:0] win_lo;
  logic [AW1-1:0]    win_hi;
  logic [AW1-1:0]    acc_lo;
  logic [AW1-1:0]    acc_hi;
  logic [3:0]        acc_bytes;
  logic              overlap;
  logic              kind_ok;

  always_comb begin
    len_m1    = ADDR_W'(len_bytes(cfg.len)) - ADDR_W'(1);
    win_lo    = bp_addr & ~len_m1;
    win_hi    = {1'b0, win_lo} + {1'b0, len_m1};
    acc_bytes = 4'd1 << acc_size;
    acc_lo    = {1'b0, acc_addr};
    acc_hi    = acc_lo + AW1'(acc_bytes - 4'd1);
    overlap   = (acc_lo <= win_hi) && ({1'b0, win_lo} <= acc_hi);
    case (cfg.cond)
      COND_WR: kind_ok = (acc_kind == KIND_DWR);
      COND_RW: kind_ok = (acc_kind == KIND_DWR) || (acc_kind == KIND_DRD);
      COND_IO: kind_ok = io_ext_en &&
                         ((acc_kind == KIND_IORD) || (acc_kind == KIND_IOWR));
      default: kind_ok = 1'b0;
    endcase
    if (cfg.cond == COND_EXEC)
      hit = (acc_kind == KIND_FETCH) && (acc_addr == bp_addr);
    else
      hit = kind_ok && overlap;
  end
endmodule

// File: rtl/bkpt_regs.sv
module bkpt_regs
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NUM_BP = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [2:0]               reg_idx,
  input  logic [REG_W-1:0]         reg_wdata,
  input  logic                     wr_ok,
  input  logic                     task_switch,
  input  logic [NUM_BP-1:0]        hit_vec,
  input  logic                     data_trap,
  input  logic                     prot_hit,
  output logic [NUM_BP*ADDR_W-1:0] bp_addr_flat,
  output logic [REG_W-1:0]         ctrl_q,
  output logic [REG_W-1:0]         stat_q
);
  logic [REG_W-1:0] ctrl_d;
  logic [REG_W-1:0] stat_d;
  logic [REG_W-1:0] local_mask;
  logic [NUM_BP-1:0] b_bits;

  always_comb begin
    local_mask = '0;
    for (int n = 0; n < NUM_BP; n++) local_mask[2*n] = 1'b1;
  end

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ok && reg_idx == IDX_CTRL)
      ctrl_d = (reg_wdata & CTRL_KEEP) | CTRL_ONES;
    if (task_switch)
      ctrl_d = ctrl_d & ~local_mask;
    if (prot_hit)
      ctrl_d[CTRL_PROT_BIT] = 1'b0;
  end

  always_comb begin
    stat_d = stat_q;
    if (wr_ok && reg_idx == IDX_STAT) begin
      stat_d = '0;
      stat_d[NUM_BP-1:0]    = reg_wdata[NUM_BP-1:0];
      stat_d[STAT_PROT_BIT] = reg_wdata[STAT_PROT_BIT];
    end
    b_bits = stat_d[NUM_BP-1:0];
    if (data_trap) b_bits = hit_vec;
    else           b_bits = b_bits | hit_vec;
    stat_d[NUM_BP-1:0] = b_bits;
    if (prot_hit) stat_d[STAT_PROT_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_ONES;
      stat_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      stat_q <= stat_d;
    end
  end

  for (genvar n = 0; n < NUM_BP; n++) begin : g_addr
    always_ff @(posedge clk) begin
      if (!rst_n)
        bp_addr_flat[n*ADDR_W +: ADDR_W] <= '0;
      else if (wr_ok && reg_idx == 3'(n))
        bp_addr_flat[n*ADDR_W +: ADDR_W] <= reg_wdata[ADDR_W-1:0];
    end
  end
endmodule

// File: rtl/bkpt_match_unit.sv
module bkpt_match_unit
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NUM_BP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        reg_idx,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              reg_we,
  input  logic              reg_re,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [2:0]        acc_kind,
  input  logic [1:0]        acc_size,
  input  logic              dbg_ext_en,
  input  logic              task_switch,
  output logic              trap,
  output logic [REG_W-1:0]  status_o
);
  logic [NUM_BP*ADDR_W-1:0] bp_addr_flat;
  logic [REG_W-1:0]         ctrl_w;
  logic [REG_W-1:0]         stat_w;
  logic [NUM_BP-1:0]        hit_raw;
  logic [NUM_BP-1:0]        hit_vec;
  logic [NUM_BP-1:0]        en_vec;
  logic                     prot_on;
  logic                     prot_hit;
  logic                     wr_ok;
  logic                     data_trap;
  logic                     trap_q;

  for (genvar n = 0; n < NUM_BP; n++) begin : g_bp
    bkpt_cmp #(.ADDR_W(ADDR_W)) u_cmp (
      .bp_addr  (bp_addr_flat[n*ADDR_W +: ADDR_W]),
      .cfg      (bp_cfg_t'(ctrl_w[CTRL_FIELD_LO + 4*n +: 4])),
      .acc_addr (acc_addr),
      .acc_kind (acc_kind),
      .acc_size (acc_size),
      .io_ext_en(dbg_ext_en),
      .hit      (hit_raw[n])
    );
    assign en_vec[n] = ctrl_w[2*n] | ctrl_w[2*n+1];
  end

  assign hit_vec   = hit_raw & {NUM_BP{acc_valid}};
  assign data_trap = |(hit_vec & en_vec);
  assign prot_on   = ctrl_w[CTRL_PROT_BIT];
  assign prot_hit  = prot_on & (reg_we | reg_re);
  assign wr_ok     = reg_we & ~prot_on;

  bkpt_regs #(.ADDR_W(ADDR_W), .NUM_BP(NUM_BP)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_idx     (reg_idx),
    .reg_wdata   (reg_wdata),
    .wr_ok       (wr_ok),
    .task_switch (task_switch),
    .hit_vec     (hit_vec),
    .data_trap   (data_trap),
    .prot_hit    (prot_hit),
    .bp_addr_flat(bp_addr_flat),
    .ctrl_q      (ctrl_w),
    .stat_q      (stat_w)
  );

  always_comb begin
    reg_rdata = '0;
    if (!prot_hit) begin
      if (int'(reg_idx) < NUM_BP)
        reg_rdata = REG_W'(bp_addr_flat[int'(reg_idx)*ADDR_W +: ADDR_W]);
      else if (reg_idx == IDX_STAT)
        reg_rdata = stat_w;
      else if (reg_idx == IDX_CTRL)
        reg_rdata = ctrl_w;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) trap_q <= 1'b0;
    else        trap_q <= data_trap | prot_hit;
  end

  assign trap     = trap_q;
  assign status_o = stat_w;
endmodule

// File: rtl/bkpt_match_unit_chk.sv
module bkpt_match_unit_chk #(
  parameter int ADDR_W = 32,
  parameter int NUM_BP = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [2:0]               reg_idx,
  input logic                     reg_we,
  input logic                     reg_re,
  input logic [31:0]              reg_rdata,
  input logic                     acc_valid,
  input logic                     task_switch,
  input logic                     trap,
  input logic [31:0]              status_o,
  input logic [31:0]              ctrl,
  input logic [NUM_BP*ADDR_W-1:0] bp_addr
);
  logic [NUM_BP-1:0] loc_en;
  logic [NUM_BP-1:0] glb_en;
  always_comb begin
    for (int n = 0; n < NUM_BP; n++) begin
      loc_en[n] = ctrl[2*n];
      glb_en[n] = ctrl[2*n+1];
    end
  end

  // R9
  trap_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> $past(acc_valid || reg_we || reg_re));

  // R2
  ctrl_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[10]);

  // R11
  ts_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    task_switch |=> (loc_en == '0));

  // R11
  ts_global_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (task_switch && !reg_we) |=> $stable(glb_en));

  // R12
  prot_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[13] && reg_we) |=> ($stable(bp_addr) && status_o[13] && !ctrl[13]));

  // R12
  prot_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[13] && reg_re) |-> (reg_rdata == 32'h0));

  // R13
  bd_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[13] && !(reg_we && reg_idx == 3'd6)) |=> status_o[13]);
endmodule

bind bkpt_match_unit bkpt_match_unit_chk #(.ADDR_W(ADDR_W), .NUM_BP(NUM_BP)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_idx    (reg_idx),
  .reg_we     (reg_we),
  .reg_re     (reg_re),
  .reg_rdata  (reg_rdata),
  .acc_valid  (acc_valid),
  .task_switch(task_switch),
  .trap       (trap),
  .status_o   (status_o),
  .ctrl       (ctrl_w),
  .bp_addr    (bp_addr_flat)
);

// File: tb/bkpt_match_unit_tb.sv
module bkpt_match_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] K_FETCH = 3'd0, K_DRD = 3'd1, K_DWR = 3'd2,
                         K_IORD = 3'd3, K_IOWR = 3'd4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [31:0] reg_rdata;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [2:0]  acc_kind = '0;
  logic [1:0]  acc_size = '0;
  logic        dbg_ext_en = 1'b0, task_switch = 1'b0;
  logic        trap;
  logic [31:0] status_o;

  int checks = 0;
  int errors = 0;

  bkpt_match_unit u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk); reg_idx = idx; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [31:0] d);
    reg_idx = idx; #1; d = reg_rdata;
  endtask

  function automatic logic [31:0] fld(input int n, input int cond, input int len);
    return (32'(cond) << (16 + 4*n)) | (32'(len) << (18 + 4*n));
  endfunction

  function automatic bit exp_hit(input int a_bp, input int lc, input int a, input int s);
    int l, base;
    l = (lc == 0) ? 1 : (lc == 1) ? 2 : (lc == 2) ? 8 : 4;
    base = a_bp & ~(l - 1);
    return (a <= base + l - 1) && (base <= a + (1 << s) - 1);
  endfunction

  task automatic acc(input logic [31:0] a, input logic [2:0] k, input logic [1:0] s);
    @(negedge clk); acc_valid = 1'b1; acc_addr = a; acc_kind = k; acc_size = s;
    @(negedge clk); acc_valid = 1'b0;
  endtask

  task automatic acc_chk(input logic [31:0] a, input logic [2:0] k, input logic [1:0] s,
                         input logic exp_trap, input logic [3:0] exp_b, input string what);
    wr(3'd6, 32'h0);
    acc(a, k, s);
    chk({31'b0, trap}, {31'b0, exp_trap}, {what, " trap"});
    chk({28'b0, status_o[3:0]}, {28'b0, exp_b}, {what, " status"});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd7, d); chk(d, 32'h400, "R1 ctrl reset");
    rd(3'd6, d); chk(d, 32'h0, "R1 status reset");
    for (int i = 0; i < 4; i++) begin rd(3'(i), d); chk(d, 32'h0, "R1 addr reset"); end
    chk({31'b0, trap}, 32'h0, "R1 trap reset");

    // R2 register map
    for (int i = 0; i < 4; i++) wr(3'(i), 32'hA5A5_0000 + 32'(i));
    for (int i = 0; i < 4; i++) begin rd(3'(i), d); chk(d, 32'hA5A5_0000 + 32'(i), "R2 addr rw"); end
    wr(3'd7, 32'hFFFF_DFFF);
    rd(3'd7, d); chk(d, 32'hFFFF_04FF, "R2 ctrl mask");
    wr(3'd7, 32'h0);
    rd(3'd7, d); chk(d, 32'h400, "R2 ctrl bit10");
    wr(3'd6, 32'hFFFF_FFFF);
    rd(3'd6, d); chk(d, 32'h0000_200F, "R2 status mask");
    wr(3'd6, 32'h0);
    wr(3'd4, 32'h1234_5678); wr(3'd5, 32'h1234_5678);
    rd(3'd4, d); chk(d, 32'h0, "R2 idx4 zero");
    rd(3'd5, d); chk(d, 32'h0, "R2 idx5 zero");
    for (int i = 0; i < 4; i++) wr(3'(i), 32'h0);

    // R4 R5 sweep: bp0 at 0x103, write-watch, local enable
    wr(3'd0, 32'h103);
    for (int lc = 0; lc < 4; lc++) begin
      wr(3'd7, fld(0, 1, lc) | 32'h1);
      for (int s = 0; s < 4; s++)
        for (int a = 'hF8; a < 'h110; a++) begin
          bit h;
          h = exp_hit('h103, lc, a, s);
          acc_chk(32'(a), K_DWR, 2'(s), h, {3'b0, h}, "R5 R4 overlap sweep");
        end
    end

    // R6 kinds
    wr(3'd0, 32'h200);
    wr(3'd7, fld(0, 1, 3) | 32'h1);
    acc_chk(32'h200, K_DWR, 2'd0, 1'b1, 4'b0001, "R6 cond01 write");
    acc_chk(32'h200, K_DRD, 2'd0, 1'b0, 4'b0000, "R6 cond01 read");
    acc_chk(32'h200, K_FETCH, 2'd0, 1'b0, 4'b0000, "R6 cond01 fetch");
    wr(3'd7, fld(0, 3, 3) | 32'h1);
    acc_chk(32'h201, K_DRD, 2'd0, 1'b1, 4'b0001, "R6 cond11 read");
    acc_chk(32'h203, K_DWR, 2'd0, 1'b1, 4'b0001, "R6 cond11 write");
    acc_chk(32'h200, K_FETCH, 2'd0, 1'b0, 4'b0000, "R6 cond11 fetch");
    acc_chk(32'h200, K_IOWR, 2'd0, 1'b0, 4'b0000, "R6 cond11 io");

    // R7 I/O condition gated by dbg_ext_en
    wr(3'd7, fld(0, 2, 3) | 32'h1);
    acc_chk(32'h200, K_IORD, 2'd0, 1'b0, 4'b0000, "R7 io ext off");
    dbg_ext_en = 1'b1;
    acc_chk(32'h200, K_IORD, 2'd0, 1'b1, 4'b0001, "R7 io read ext on");
    acc_chk(32'h202, K_IOWR, 2'd0, 1'b1, 4'b0001, "R7 io write ext on");
    acc_chk(32'h200, K_DWR, 2'd0, 1'b0, 4'b0000, "R7 io vs data");
    dbg_ext_en = 1'b0;

    // R8 execution condition
    wr(3'd0, 32'h300);
    wr(3'd7, fld(0, 0, 0) | 32'h1);
    acc_chk(32'h300, K_FETCH, 2'd0, 1'b1, 4'b0001, "R8 fetch exact");
    acc_chk(32'h301, K_FETCH, 2'd0, 1'b0, 4'b0000, "R8 fetch off by one");
    acc_chk(32'h300, K_DWR, 2'd0, 1'b0, 4'b0000, "R8 data at exec addr");
    wr(3'd7, fld(0, 0, 3) | 32'h1);
    acc_chk(32'h301, K_FETCH, 2'd0, 1'b0, 4'b0000, "R8 length ignored");

    // R9 disabled match sets status only; pulse width
    wr(3'd0, 32'h200);
    wr(3'd7, fld(0, 1, 0));
    acc_chk(32'h200, K_DWR, 2'd0, 1'b0, 4'b0001, "R9 disabled sets status");
    wr(3'd7, fld(0, 1, 0) | 32'h1);
    acc_chk(32'h200, K_DWR, 2'd0, 1'b1, 4'b0001, "R9 enabled traps");
    @(negedge clk);
    chk({31'b0, trap}, 32'h0, "R9 one-cycle pulse");

    // R3 enable bit positions
    wr(3'd2, 32'h400);
    wr(3'd7, fld(2, 1, 0) | 32'h20);
    acc_chk(32'h400, K_DWR, 2'd0, 1'b1, 4'b0100, "R3 global only");
    wr(3'd7, fld(2, 1, 0) | 32'h08);
    acc_chk(32'h400, K_DWR, 2'd0, 1'b0, 4'b0100, "R3 other bp enable");
    wr(3'd7, fld(2, 1, 0) | 32'h10);
    acc_chk(32'h400, K_DWR, 2'd0, 1'b1, 4'b0100, "R3 local only");

    // R10 trap reloads, non-trap ORs
    wr(3'd1, 32'h500); wr(3'd2, 32'h600);
    wr(3'd7, fld(1, 3, 0) | fld(2, 3, 0) | 32'h04);
    acc_chk(32'h600, K_DRD, 2'd0, 1'b0, 4'b0100, "R10 untrapped hit");
    acc(32'h500, K_DRD, 2'd0);
    chk({28'b0, status_o[3:0]}, 32'h2, "R10 trap reloads");
    acc(32'h600, K_DRD, 2'd0);
    chk({28'b0, status_o[3:0]}, 32'h6, "R10 or-in");
    chk({31'b0, trap}, 32'h0, "R10 no trap on disabled");

    // R11 task switch clears local enables, wins over write
    @(negedge clk); reg_idx = 3'd7; reg_wdata = 32'h0F; reg_we = 1'b1; task_switch = 1'b1;
    @(negedge clk); reg_we = 1'b0; task_switch = 1'b0;
    rd(3'd7, d); chk(d, 32'h40A, "R11 switch with write");
    wr(3'd7, 32'hFF);
    @(negedge clk); task_switch = 1'b1;
    @(negedge clk); task_switch = 1'b0;
    rd(3'd7, d); chk(d, 32'h4AA, "R11 switch keeps globals");

    // R12 protection on write
    wr(3'd6, 32'h0);
    wr(3'd0, 32'h777);
    wr(3'd7, 32'h2000);
    @(negedge clk); reg_idx = 3'd0; reg_wdata = 32'hDEAD; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
    chk({31'b0, trap}, 32'h1, "R12 write trap");
    chk({31'b0, status_o[13]}, 32'h1, "R12 BD set");
    rd(3'd0, d); chk(d, 32'h777, "R12 write suppressed");
    rd(3'd7, d); chk(d, 32'h400, "R12 protect cleared");
    // R12 protection on read
    wr(3'd7, 32'h2000);
    @(negedge clk); reg_idx = 3'd0; reg_re = 1'b1; #1;
    chk(reg_rdata, 32'h0, "R12 read data blanked");
    @(negedge clk); reg_re = 1'b0;
    chk({31'b0, trap}, 32'h1, "R12 read trap");

    // R13 BD survives data trap, cleared by software
    wr(3'd0, 32'h200);
    wr(3'd7, fld(0, 1, 0) | 32'h1);
    acc(32'h200, K_DWR, 2'd0);
    chk(status_o, 32'h2001, "R13 BD sticky on data trap");
    wr(3'd6, 32'h0);
    chk(status_o, 32'h0, "R13 software clear");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule